// File: doc/BRIEF.md
# Byte-Wide One-Time-Programmable Memory Mode Model

This block is a synthesizable behavioural model of a byte-wide read-only memory whose cells can be cleared from one to zero by programming and returned to ones only by a bulk erase. A chip-select and an output-gate input, both active low, work together with two flags. The first flag marks that the elevated programming supply is present. The second flag marks that the identifier voltage is present on address line 9. From these inputs the block decodes read, standby, output-disabled, program, program-verify, program-inhibit and identifier operation.

The data bus is modelled as a separate write-data input plus an output byte with a drive-enable flag. The output byte reads zero whenever the drive-enable flag is low. Reads are combinational from the array. Programming and erase take effect on the rising clock edge. The identifier mode returns two parity-protected bytes, a maker code and a device code. Their 7-bit payloads are parameters, and the top bit is computed by the logic.

Top module: `otp_rom_model`

## Requirements
- R1: A synchronous reset (rst_n low at a rising edge) sets every word to 8'hFF.
- R2: With ce_n=0, oe_n=0 and vpp_hi=0 (identifier not selected), dq_oe is 1 and dq_out equals the word at addr in the same cycle.
- R3: With ce_n=1, dq_oe is 0 and dq_out is 8'h00 whatever oe_n, vpp_hi and a9_hv are.
- R4: With ce_n=0, oe_n=1 and vpp_hi=0, dq_oe is 0, dq_out is 8'h00 and no word changes.
- R5: With vpp_hi=1, ce_n=0 and oe_n=1 at a rising edge, the word at addr becomes its old value ANDed with din; the new value is visible after that edge.
- R6: Programming never turns a 0 bit back to 1; only erase or reset restores ones.
- R7: With vpp_hi=1 and ce_n=1 no word changes, and the outputs stay undriven.
- R8: With vpp_hi=1, ce_n=0 and oe_n=0, dq_oe is 1, dq_out shows the word at addr, and no word changes.
- R9: In a read (R2 conditions) with a9_hv=1 and every address bit other than bit 0 and bit 9 equal to 0, dq_out is the maker byte when addr[0]=0 and the device byte when addr[0]=1. Each byte is {parity, payload}, with the payload in bits 6..0.
- R10: In a read with a9_hv=1 but any address bit other than bit 0 and bit 9 set, the array word at addr is returned.
- R11: erase=1 at a rising edge sets every word to 8'hFF and takes priority over a program requested in the same cycle.
- R12: Both identifier bytes have an odd number of ones over all 8 bits, with bit 7 as the parity bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for program, erase and reset |
| rst_n | input | 1 | Synchronous active-low reset, fills the array with ones |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| vpp_hi | input | 1 | Programming supply present |
| a9_hv | input | 1 | Identifier voltage present on address line 9 |
| erase | input | 1 | Synchronous bulk erase to all ones |
| addr | input | ADDR_W | Word address |
| din | input | 8 | Data to program |
| dq_out | output | 8 | Output byte, zero when not driven |
| dq_oe | output | 1 | Output drive enable |

## Verification
On every cycle the assertions check several properties. They check that a deselected part never drives the bus, and that an asserted output gate with chip select always drives it. They check that a disabled output gate releases the bus, and that identifier bytes always carry odd parity. They also check that erase leaves ones behind, and that bits seen at a steadily read address never rise without an erase. Other behaviours are shown only by the bench's scenarios, which compare against its reference model on every clock. These are the AND-accumulation of successive programs, program inhibit, the absence of writes during verify and output-disabled cycles, the address qualification of identifier mode, and the priority of erase over a concurrent program.

// File: rtl/otp_rom_model.sv
module otp_rom_model #(
  parameter int ADDR_W = 10,
  parameter logic [6:0] MAKER_ID = 7'h01,
  parameter logic [6:0] DEVICE_ID = 7'h11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              vpp_hi,
  input  logic              a9_hv,
  input  logic              erase,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dq_out,
  output logic              dq_oe
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] ID_MASK = ~(ADDR_W'(1) | (ADDR_W'(1) << 9));

  logic [7:0] mem [DEPTH];

  wire sel        = !ce_n;
  wire prog_mode  = sel && vpp_hi && oe_n;
  wire vfy_mode   = sel && vpp_hi && !oe_n;
  wire read_mode  = sel && !vpp_hi && !oe_n;
  wire id_hit     = read_mode && a9_hv && ((addr & ID_MASK) == '0);

  wire [7:0] maker_byte  = {~^MAKER_ID, MAKER_ID};
  wire [7:0] device_byte = {~^DEVICE_ID, DEVICE_ID};
  wire [7:0] id_byte     = addr[0] ? device_byte : maker_byte;

  always_ff @(posedge clk) begin
    if (!rst_n || erase) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (prog_mode) begin
      mem[addr] <= mem[addr] & din;
    end
  end

  assign dq_oe  = read_mode || vfy_mode;
  assign dq_out = !dq_oe ? 8'h00 : (id_hit ? id_byte : mem[addr]);
endmodule

// File: rtl/otp_rom_model_chk.sv
module otp_rom_model_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic              vpp_hi,
  input logic              a9_hv,
  input logic              erase,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        dq_out,
  input logic              dq_oe
);
  localparam logic [ADDR_W-1:0] OTHER_LINES = ~(ADDR_W'(1) | (ADDR_W'(1) << 9));

  wire id_sel  = !ce_n && !oe_n && !vpp_hi && a9_hv && ((addr & OTHER_LINES) == '0);
  wire arr_rd  = !ce_n && !oe_n && !id_sel;

  p_standby_hiz_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> (!dq_oe && dq_out == 8'h00));

  p_read_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n) |-> dq_oe);

  p_out_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && oe_n) |-> (!dq_oe && dq_out == 8'h00));

  p_id_odd_parity_r12: assert property (@(posedge clk) disable iff (!rst_n)
    id_sel |-> (^dq_out == 1'b1));

  p_erase_ones_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(erase) && arr_rd) |-> (dq_out == 8'hFF));

  p_bits_only_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_rd && $past(arr_rd) && $past(rst_n) && !$past(erase) && $stable(addr))
      |-> ((dq_out & ~$past(dq_out)) == 8'h00));
endmodule

bind otp_rom_model otp_rom_model_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
  .a9_hv(a9_hv), .erase(erase), .addr(addr), .dq_out(dq_out), .dq_oe(dq_oe)
);

// File: tb/otp_rom_model_bench.sv
`timescale 1ns/1ps
module otp_rom_model_bench;
  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;
  localparam logic [6:0] MK = 7'h01;
  localparam logic [6:0] DV = 7'h11;

  logic clk = 0, rst_n = 0, ce_n = 1, oe_n = 1, vpp_hi = 0, a9_hv = 0, erase = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = 8'hFF;
  logic [7:0] dq_out;
  logic dq_oe;

  int errors = 0, checks = 0;
  bit done = 0;
  string tag = "R1";
  logic [7:0] model [DEPTH];

  always #5 clk = ~clk;

  otp_rom_model #(.ADDR_W(AW), .MAKER_ID(MK), .DEVICE_ID(DV)) u_otp_rom_model (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
    .a9_hv(a9_hv), .erase(erase), .addr(addr), .din(din),
    .dq_out(dq_out), .dq_oe(dq_oe));

  function automatic logic [7:0] id_of(logic [6:0] p);
    return {($countones(p) % 2 == 0) ? 1'b1 : 1'b0, p};
  endfunction

  always @(posedge clk) begin
    if (!rst_n || erase) begin
      for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    end else if (vpp_hi && !ce_n && oe_n) begin
      model[addr] = model[addr] & din;
    end
  end

  function automatic bit id_mode();
    bit other_zero = 1;
    for (int b = 0; b < AW; b++)
      if (b != 0 && b != 9 && addr[b]) other_zero = 0;
    return !ce_n && !oe_n && !vpp_hi && a9_hv && other_zero;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [7:0] e_out;
      logic e_oe;
      if (ce_n || oe_n) begin e_oe = 0; e_out = 8'h00; end
      else begin
        e_oe = 1;
        if (id_mode()) e_out = addr[0] ? id_of(DV) : id_of(MK);
        else e_out = model[addr];
      end
      checks++;
      if (dq_oe !== e_oe || dq_out !== e_out) begin
        errors++;
        $display("FAIL %s: addr=%0h dq_oe=%b dq_out=%h expected dq_oe=%b dq_out=%h",
                 tag, addr, dq_oe, dq_out, e_oe, e_out);
      end
      if (id_mode()) begin
        checks++;
        if ($countones(dq_out) % 2 != 1) begin
          errors++;
          $display("FAIL R12: id byte %h has even parity, expected odd", dq_out);
        end
      end
    end
  end

  task automatic drive(input string t, input logic c, input logic o, input logic v,
                       input logic a9, input logic er, input int ad, input logic [7:0] d);
    tag = t; ce_n = c; oe_n = o; vpp_hi = v; a9_hv = a9; erase = er;
    addr = AW'(ad); din = d;
    @(posedge clk); #1;
  endtask

  task automatic rd(input string t, input int ad);
    drive(t, 0, 0, 0, 0, 0, ad, 8'hFF);
  endtask

  task automatic pgm(input string t, input int ad, input logic [7:0] d);
    drive(t, 0, 1, 1, 0, 0, ad, d);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    rd("R1", 0); rd("R1", 1); rd("R1", 513); rd("R1", DEPTH - 1);
    // R3 standby ignores oe_n, vpp_hi, a9_hv
    drive("R3", 1, 0, 0, 0, 0, 4, 8'h00);
    drive("R3", 1, 0, 0, 1, 0, 0, 8'h00);
    // R5 program and read back (R2)
    pgm("R5", 5, 8'hA5);
    rd("R2", 5); rd("R2", 6);
    // R6 AND accumulation, ones never return
    pgm("R6", 5, 8'h5A); rd("R6", 5);
    pgm("R6", 5, 8'hFF); rd("R6", 5);
    pgm("R6", 9, 8'hF0); pgm("R6", 9, 8'h3C); rd("R6", 9);
    // R7 inhibit: vpp_hi with ce_n high
    drive("R7", 1, 1, 1, 0, 0, 7, 8'h00);
    drive("R7", 1, 0, 1, 0, 0, 7, 8'h00);
    rd("R7", 7);
    // R4 output disabled, no write
    drive("R4", 0, 1, 0, 0, 0, 8, 8'h00);
    rd("R4", 8);
    // R8 verify drives data, no write
    drive("R8", 0, 0, 1, 0, 0, 9, 8'h00);
    drive("R8", 0, 0, 1, 0, 0, 10, 8'h00);
    rd("R8", 10);
    // R9 / R12 identifier bytes
    drive("R9", 0, 0, 0, 1, 0, 0, 8'hFF);
    drive("R9", 0, 0, 0, 1, 0, 1, 8'hFF);
    drive("R9", 0, 0, 0, 1, 0, 512, 8'hFF);
    drive("R12", 0, 0, 0, 1, 0, 513, 8'hFF);
    // R10 identifier flag with other lines set reads the array
    drive("R10", 0, 0, 0, 1, 0, 5, 8'hFF);
    drive("R10", 0, 0, 0, 1, 0, 9, 8'hFF);
    drive("R10", 0, 0, 0, 1, 0, 2, 8'hFF);
    // R11 erase beats a concurrent program
    pgm("R11", 3, 8'h0F);
    drive("R11", 0, 1, 1, 0, 1, 3, 8'h00);
    rd("R11", 3); rd("R11", 5); rd("R11", 9); rd("R11", 7);
    // R2 patterns after erase
    pgm("R2", 100, 8'h81); pgm("R2", 1000, 8'h7E);
    rd("R2", 100); rd("R2", 1000); rd("R2", 101);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule